// File: doc/BRIEF.md
# Regular-Group Conversion Sequencer

This block runs the conversion sequence of a multi-channel analog-to-digital converter for one regular group of channels. A list of up to sixteen ranks, each naming a 5-bit channel, sets the order of conversion. Every channel has its own sampling-time code. One resolution setting applies to the whole group and sets the processing time. For each rank the block drives the channel number to a converter stub. It then opens a sampling window and a converting window of the computed length, and captures the stub's result at the close of the converting window.

Each pass is started by a software pulse or by a chosen edge of an external trigger. Four controls shape what a trigger does: scan, continuous, discontinuous and sub-group size. A trigger can convert a single channel, the whole list once, the list over and over, or only the next slice of the list. The end-of-conversion flag is raised either after every rank or only after the last rank. Reading the data clears it. In per-rank mode, an unread result that is overwritten raises an overrun flag and stops the sequencer.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, busy, eoc, ovr, conv_sample, conv_convert and dout are all zero.
- R2: With cfg_scan low, a trigger converts only the channel of rank 1, and cfg_seq_len is ignored.
- R3: With cfg_scan high, ranks are converted in rising order from rank 1 to rank cfg_seq_len+1. cfg_seq_len is a 4-bit field holding the length minus one. Rank r's channel is cfg_rank_ch[5r+4:5r], with rank 1 at r=0.
- R4: A conversion takes S+P cycles. S is the sampling time of the channel's 3-bit code (0..7 map to 3, 15, 28, 56, 84, 112, 144, 480). P is the processing time of cfg_res (0: 12-bit, 12; 1: 10-bit, 11; 2: 8-bit, 9; 3: 6-bit, 7). eoc is seen S+P cycles after the edge that samples the trigger.
- R5: conv_data is captured into dout on the last converting cycle of each rank.
- R6: With cfg_cont low, the block stops after one pass. busy rises on the edge that accepts the trigger and falls on the edge that captures the pass's last result.
- R7: With cfg_cont high, the list restarts from rank 1 after its last rank, and busy stays high. Continuous mode overrides cfg_disc. Clearing cfg_cont ends the run at the end of the current pass.
- R8: With cfg_disc high, cfg_scan high and cfg_cont low, each trigger converts the next cfg_disc_len+1 ranks, or fewer if the list ends first. The next trigger resumes at the following rank and wraps to rank 1 after the last.
- R9: cfg_edge selects the external trigger: 0 none, 1 rising, 2 falling, 3 both edges. sw_start always starts a pass.
- R10: With cfg_eoc_per_rank high, eoc is set after every rank. With it low, eoc is set only after the last rank of the list. A one-cycle rd_strobe clears eoc.
- R11: In per-rank mode, a result captured while eoc is still set raises ovr and aborts the pass. Triggers are ignored until ovr_clr, and the next pass starts at rank 1.
- R12: Triggers that arrive while busy is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_seq_len | input | 4 | Sequence length minus one |
| cfg_rank_ch | input | 80 | Channel of each rank, 5 bits per rank |
| cfg_smp_code | input | 96 | Sampling-time code per channel, 3 bits each |
| cfg_res | input | 2 | Resolution code |
| cfg_scan | input | 1 | Scan enable |
| cfg_cont | input | 1 | Continuous enable |
| cfg_disc | input | 1 | Discontinuous enable |
| cfg_disc_len | input | 3 | Sub-group size minus one |
| cfg_edge | input | 2 | External trigger edge select |
| cfg_eoc_per_rank | input | 1 | 1: eoc after each rank, 0: after sequence |
| sw_start | input | 1 | Software start pulse |
| ext_trig | input | 1 | External trigger level |
| rd_strobe | input | 1 | Data read, clears eoc |
| ovr_clr | input | 1 | Clears the overrun flag |
| conv_data | input | 12 | Result from the converter stub |
| conv_ch | output | 5 | Channel being converted |
| conv_sample | output | 1 | Sampling window |
| conv_convert | output | 1 | Converting window |
| dout | output | 12 | Last captured result |
| eoc | output | 1 | End-of-conversion flag |
| ovr | output | 1 | Overrun flag |
| busy | output | 1 | Pass in progress |

## Verification
The bench measures the trigger-to-eoc latency across a table of sampling codes and resolutions. An off-by-one window count would shift each of these latencies by a cycle. It walks the discontinuous slices past the end of the list to catch a pointer that fails to wrap, or one that restarts every slice at rank 1. It forces an overrun and then checks three things: that no further rank runs, that a trigger is ignored while the flag is set, and that the next pass starts again at rank 1. It also fires triggers in the middle of a long conversion, and edges of every polarity under each edge setting. A design that restarted, or that counted an unselected edge, would log an extra conversion.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    localparam int CNT_W = 9;

    typedef enum logic [1:0] {RES_12 = 2'd0, RES_10 = 2'd1, RES_8 = 2'd2, RES_6 = 2'd3} res_e;
    typedef enum logic [1:0] {EDGE_NONE = 2'd0, EDGE_RISE = 2'd1, EDGE_FALL = 2'd2, EDGE_BOTH = 2'd3} edge_e;
    typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_SAMPLE = 2'd1, PH_CONVERT = 2'd2} phase_e;

    function automatic logic [CNT_W-1:0] sample_cycles(input logic [2:0] code);
        case (code)
            3'd0:    return 9'd3;
            3'd1:    return 9'd15;
            3'd2:    return 9'd28;
            3'd3:    return 9'd56;
            3'd4:    return 9'd84;
            3'd5:    return 9'd112;
            3'd6:    return 9'd144;
            default: return 9'd480;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] proc_cycles(input res_e res);
        case (res)
            RES_12:  return 9'd12;
            RES_10:  return 9'd11;
            RES_8:   return 9'd9;
            default: return 9'd7;
        endcase
    endfunction

endpackage

// File: rtl/adcseq_trig.sv
module adcseq_trig
    import adcseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sw_start,
    input  logic       ext_trig,
    input  logic [1:0] edge_sel,
    output logic       start_req
);
    logic prev_q;
    logic rise, fall, ext_evt;

    assign rise = ext_trig & ~prev_q;
    assign fall = ~ext_trig & prev_q;

    always_comb begin
        case (edge_e'(edge_sel))
            EDGE_RISE: ext_evt = rise;
            EDGE_FALL: ext_evt = fall;
            EDGE_BOTH: ext_evt = rise | fall;
            default:   ext_evt = 1'b0;
        endcase
    end

    assign start_req = sw_start | ext_evt;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= ext_trig;
    end
endmodule

// File: rtl/adcseq_window.sv
module adcseq_window
    import adcseq_pkg::*;
#(
    parameter int W = CNT_W
)(
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] smp_len,
    input  logic [W-1:0] proc_len,
    output logic         sampling,
    output logic         converting,
    output logic         done
);
    phase_e       ph_q;
    logic [W-1:0] cnt_q;

    assign sampling   = (ph_q == PH_SAMPLE);
    assign converting = (ph_q == PH_CONVERT);
    assign done       = converting && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: if (start) begin
                    ph_q  <= PH_SAMPLE;
                    cnt_q <= smp_len - 1'b1;
                end
                PH_SAMPLE: if (cnt_q == '0) begin
                    ph_q  <= PH_CONVERT;
                    cnt_q <= proc_len - 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
                PH_CONVERT: if (cnt_q == '0) begin
                    if (start) begin
                        ph_q  <= PH_SAMPLE;
                        cnt_q <= smp_len - 1'b1;
                    end else begin
                        ph_q <= PH_IDLE;
                    end
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // R4: shortest sampling and processing times exceed one cycle
    a_r4_convert_min: assert property (@(posedge clk) disable iff (rst)
        $rose(converting) |=> converting);
    a_r4_sample_min: assert property (@(posedge clk) disable iff (rst)
        $rose(sampling) |=> sampling);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adcseq_pkg::*;
#(
    parameter int MAX_RANKS = 16,
    parameter int CH_W      = 5,
    parameter int DATA_W    = 12,
    parameter int DISC_W    = 3,
    localparam int NUM_CH   = 1 << CH_W,
    localparam int RANK_W   = $clog2(MAX_RANKS)
)(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [RANK_W-1:0]         cfg_seq_len,
    input  logic [MAX_RANKS*CH_W-1:0] cfg_rank_ch,
    input  logic [NUM_CH*3-1:0]       cfg_smp_code,
    input  logic [1:0]                cfg_res,
    input  logic                      cfg_scan,
    input  logic                      cfg_cont,
    input  logic                      cfg_disc,
    input  logic [DISC_W-1:0]         cfg_disc_len,
    input  logic [1:0]                cfg_edge,
    input  logic                      cfg_eoc_per_rank,
    input  logic                      sw_start,
    input  logic                      ext_trig,
    input  logic                      rd_strobe,
    input  logic                      ovr_clr,
    input  logic [DATA_W-1:0]         conv_data,
    output logic [CH_W-1:0]           conv_ch,
    output logic                      conv_sample,
    output logic                      conv_convert,
    output logic [DATA_W-1:0]         dout,
    output logic                      eoc,
    output logic                      ovr,
    output logic                      busy
);
    typedef struct packed {
        logic seq_end;
        logic grp_end;
        logic overrun;
        logic go_on;
    } step_t;

    logic [RANK_W-1:0] rank_q, start_rank, next_rank, last_rank, win_rank;
    logic [DISC_W-1:0] sub_q;
    logic              busy_q, eoc_q, ovr_q;
    logic [DATA_W-1:0] dout_q;
    logic              start_req, accept, disc_eff;
    logic              win_start, win_done, sampling, converting;
    logic [CH_W-1:0]   win_ch;
    logic [CNT_W-1:0]  win_smp, win_proc;
    step_t             step;

    adcseq_trig u_trig (
        .clk       (clk),
        .rst       (rst),
        .sw_start  (sw_start),
        .ext_trig  (ext_trig),
        .edge_sel  (cfg_edge),
        .start_req (start_req)
    );

    assign disc_eff   = cfg_disc & cfg_scan & ~cfg_cont;
    assign last_rank  = cfg_scan ? cfg_seq_len : '0;
    assign start_rank = disc_eff ? rank_q : '0;
    assign accept     = start_req & ~busy_q & ~ovr_q;

    always_comb begin
        step.seq_end = (rank_q == last_rank);
        step.grp_end = disc_eff && (sub_q == cfg_disc_len);
        step.overrun = win_done & cfg_eoc_per_rank & eoc_q & ~rd_strobe;
        step.go_on   = win_done & ~step.overrun &
                       ((step.seq_end & cfg_cont) | (~step.seq_end & ~step.grp_end));
    end

    assign next_rank = step.seq_end ? '0 : rank_q + 1'b1;
    assign win_rank  = accept ? start_rank : next_rank;
    assign win_ch    = cfg_rank_ch[win_rank*CH_W +: CH_W];
    assign win_smp   = sample_cycles(cfg_smp_code[win_ch*3 +: 3]);
    assign win_proc  = proc_cycles(res_e'(cfg_res));
    assign win_start = accept | step.go_on;

    adcseq_window #(.W(CNT_W)) u_win (
        .clk        (clk),
        .rst        (rst),
        .start      (win_start),
        .smp_len    (win_smp),
        .proc_len   (win_proc),
        .sampling   (sampling),
        .converting (converting),
        .done       (win_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rank_q <= '0;
            sub_q  <= '0;
            busy_q <= 1'b0;
            eoc_q  <= 1'b0;
            ovr_q  <= 1'b0;
            dout_q <= '0;
        end else begin
            if (accept) begin
                busy_q <= 1'b1;
                rank_q <= start_rank;
                sub_q  <= '0;
            end
            if (win_done) begin
                dout_q <= conv_data;
                rank_q <= next_rank;
                if (step.overrun) begin
                    busy_q <= 1'b0;
                    rank_q <= '0;
                    sub_q  <= '0;
                end else if (step.go_on) begin
                    sub_q <= step.seq_end ? '0 : sub_q + 1'b1;
                end else begin
                    busy_q <= 1'b0;
                    sub_q  <= '0;
                end
            end
            if (win_done && (cfg_eoc_per_rank || step.seq_end)) eoc_q <= 1'b1;
            else if (rd_strobe)                                 eoc_q <= 1'b0;
            if (step.overrun)  ovr_q <= 1'b1;
            else if (ovr_clr)  ovr_q <= 1'b0;
        end
    end

    assign conv_ch      = cfg_rank_ch[rank_q*CH_W +: CH_W];
    assign conv_sample  = sampling;
    assign conv_convert = converting;
    assign dout         = dout_q;
    assign eoc          = eoc_q;
    assign ovr          = ovr_q;
    assign busy         = busy_q;

    // R11: a halted sequencer opens no new window
    a_r11_halt_no_sample: assert property (@(posedge clk) disable iff (rst)
        ovr_q |-> !sampling);
    // R6: windows only inside a busy pass
    a_r6_window_in_busy: assert property (@(posedge clk) disable iff (rst)
        (sampling || converting) |-> busy_q);
    // R10: sequence-end mode raises eoc only after the last rank
    a_r10_seq_eoc_last: assert property (@(posedge clk) disable iff (rst)
        ($rose(eoc_q) && $past(!cfg_eoc_per_rank)) |-> $past(rank_q == last_rank));
    // R2: with scan off the pointer stays on rank 1
    a_r2_scan_off_rank: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !cfg_scan) |-> (rank_q == '0));
endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cfg_seq_len = '0;
    logic [79:0] cfg_rank_ch = '0;
    logic [95:0] cfg_smp_code = '0;
    logic [1:0]  cfg_res = 2'd3;
    logic        cfg_scan = 0, cfg_cont = 0, cfg_disc = 0, cfg_eoc_per_rank = 0;
    logic [2:0]  cfg_disc_len = '0;
    logic [1:0]  cfg_edge = '0;
    logic        sw_start = 0, ext_trig = 0, rd_strobe = 0, ovr_clr = 0;
    logic [11:0] conv_data;
    logic [4:0]  conv_ch;
    logic        conv_sample, conv_convert, eoc, ovr, busy;
    logic [11:0] dout;

    int errors = 0;
    int checks = 0;
    int logch[256];
    int logn = 0;
    logic smp_prev = 0;

    always #5 clk = ~clk;

    function automatic logic [11:0] dval(input logic [4:0] ch);
        return 12'h800 + 12'(ch) * 12'd37;
    endfunction

    assign conv_data = dval(conv_ch);

    adc_seq_ctrl uut (
        .clk(clk), .rst(rst), .cfg_seq_len(cfg_seq_len), .cfg_rank_ch(cfg_rank_ch),
        .cfg_smp_code(cfg_smp_code), .cfg_res(cfg_res), .cfg_scan(cfg_scan),
        .cfg_cont(cfg_cont), .cfg_disc(cfg_disc), .cfg_disc_len(cfg_disc_len),
        .cfg_edge(cfg_edge), .cfg_eoc_per_rank(cfg_eoc_per_rank), .sw_start(sw_start),
        .ext_trig(ext_trig), .rd_strobe(rd_strobe), .ovr_clr(ovr_clr),
        .conv_data(conv_data), .conv_ch(conv_ch), .conv_sample(conv_sample),
        .conv_convert(conv_convert), .dout(dout), .eoc(eoc), .ovr(ovr), .busy(busy)
    );

    // conversion-start monitor: logs the channel of each new sampling window
    always @(negedge clk) begin
        if (conv_sample && !smp_prev && logn < 256) begin
            logch[logn] = int'(conv_ch);
            logn = logn + 1;
        end
        smp_prev = conv_sample;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_sw();
        @(negedge clk) sw_start = 1'b1;
        @(negedge clk) sw_start = 1'b0;
    endtask

    task automatic pulse_rd();
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
    endtask

    // waits for the pass to end; returns how often eoc was seen while busy
    task automatic wait_idle(output int eoc_busy);
        eoc_busy = 0;
        tick(2);
        for (int i = 0; i < 5000 && busy; i++) begin
            if (eoc) eoc_busy++;
            @(negedge clk);
        end
    endtask

    localparam int VEC[5][3] = '{'{0, 3, 10}, '{1, 0, 27}, '{2, 1, 39},
                                 '{3, 0, 68}, '{7, 2, 489}};

    initial begin
        int n, base, eb, nrd;
        int got[8];
        for (int i = 0; i < 16; i++) cfg_rank_ch[i*5 +: 5] = 5'(i + 12);
        cfg_rank_ch[0 +: 5] = 5'd5;  cfg_rank_ch[5 +: 5]  = 5'd9;
        cfg_rank_ch[10 +: 5] = 5'd2; cfg_rank_ch[15 +: 5] = 5'd7;
        cfg_rank_ch[20 +: 5] = 5'd11;

        // R1: reset state
        tick(3);
        check("R1 busy", int'(busy), 0);
        check("R1 eoc", int'(eoc), 0);
        check("R1 ovr", int'(ovr), 0);
        check("R1 dout", int'(dout), 0);
        check("R1 windows", int'(conv_sample | conv_convert), 0);
        @(negedge clk) rst = 1'b0;
        check("R1 after release", int'(busy | eoc | ovr | conv_sample), 0);

        // R4/R5/R6/R10: latency table, scan off, rank 1 = channel 5
        for (int v = 0; v < 5; v++) begin
            cfg_smp_code[15 +: 3] = 3'(VEC[v][0]);
            cfg_res = 2'(VEC[v][1]);
            @(negedge clk) sw_start = 1'b1;
            @(negedge clk) sw_start = 1'b0;
            n = 0;
            while (!eoc && n < 2000) begin @(negedge clk); n++; end
            check("R4 latency", n, VEC[v][2]);
            check("R5 data", int'(dout), int'(dval(5'd5)));
            check("R6 busy falls with last capture", int'(busy), 0);
            pulse_rd();
            check("R10 read clears eoc", int'(eoc), 0);
        end
        cfg_smp_code[15 +: 3] = 3'd0;
        cfg_res = 2'd3;

        // R2: scan off ignores length
        cfg_seq_len = 4'd3;
        base = logn;
        pulse_sw(); wait_idle(eb);
        check("R2 count", logn - base, 1);
        check("R2 channel", logch[base], 5);

        // R3/R10: scan on, eoc at sequence end only
        cfg_scan = 1'b1; cfg_seq_len = 4'd2;
        pulse_rd();
        base = logn;
        pulse_sw(); wait_idle(eb);
        check("R3 count", logn - base, 3);
        check("R3 rank1", logch[base], 5);
        check("R3 rank2", logch[base+1], 9);
        check("R3 rank3", logch[base+2], 2);
        check("R10 no eoc mid-sequence", eb, 0);
        check("R10 eoc at end", int'(eoc), 1);
        check("R5 last data", int'(dout), int'(dval(5'd2)));
        pulse_rd();

        // R10: per-rank eoc with reads, no overrun
        cfg_eoc_per_rank = 1'b1;
        pulse_sw();
        nrd = 0;
        for (int k = 0; k < 500; k++) begin
            @(negedge clk);
            if (eoc) begin
                if (nrd < 8) got[nrd] = int'(dout);
                nrd++;
                rd_strobe = 1'b1;
            end else rd_strobe = 1'b0;
            if (!busy && !eoc && k > 2) break;
        end
        rd_strobe = 1'b0;
        check("R10 per-rank reads", nrd, 3);
        check("R10 read1", got[0], int'(dval(5'd5)));
        check("R10 read3", got[2], int'(dval(5'd2)));
        check("R11 no overrun when read", int'(ovr), 0);

        // R11: overrun halts and blocks triggers
        base = logn;
        pulse_sw(); wait_idle(eb);
        check("R11 ovr set", int'(ovr), 1);
        check("R11 halted after 2", logn - base, 2);
        check("R11 overwritten data", int'(dout), int'(dval(5'd9)));
        tick(40);
        pulse_sw(); tick(40);
        check("R11 trigger ignored", logn - base, 2);
        check("R11 busy low", int'(busy), 0);
        @(negedge clk) ovr_clr = 1'b1;
        @(negedge clk) ovr_clr = 1'b0;
        check("R11 cleared", int'(ovr), 0);
        pulse_rd();
        base = logn;
        pulse_sw(); wait_idle(eb);
        check("R11 restart at rank1", logch[base], 5);
        @(negedge clk) ovr_clr = 1'b1;
        @(negedge clk) ovr_clr = 1'b0;
        pulse_rd();
        cfg_eoc_per_rank = 1'b0;

        // R8: discontinuous slices of 2 over 5 ranks
        cfg_seq_len = 4'd4; cfg_disc = 1'b1; cfg_disc_len = 3'd1;
        base = logn;
        pulse_sw(); wait_idle(eb);
        check("R8 slice1 count", logn - base, 2);
        check("R8 slice1 b", logch[base+1], 9);
        pulse_sw(); wait_idle(eb);
        check("R8 slice2 count", logn - base, 4);
        check("R8 slice2 a", logch[base+2], 2);
        check("R8 slice2 b", logch[base+3], 7);
        pulse_sw(); wait_idle(eb);
        check("R8 short tail", logn - base, 5);
        check("R8 tail ch", logch[base+4], 11);
        pulse_sw(); wait_idle(eb);
        check("R8 wrap count", logn - base, 7);
        check("R8 wrap ch", logch[base+5], 5);
        pulse_rd();

        // R7: continuous overrides discontinuous
        cfg_seq_len = 4'd1; cfg_cont = 1'b1;
        pulse_sw();
        base = logn - 0;
        for (int k = 0; k < 2000 && (logn - base) < 5; k++) @(negedge clk);
        check("R7 busy held", int'(busy), 1);
        cfg_cont = 1'b0;
        wait_idle(eb);
        check("R7 total", logn - base, 6);
        check("R7 ch3", logch[base+2], 5);
        check("R7 ch4", logch[base+3], 9);
        check("R7 final data", int'(dout), int'(dval(5'd9)));
        cfg_disc = 1'b0; cfg_scan = 1'b0;
        pulse_rd();

        // R9: external edge selection
        base = logn;
        cfg_edge = 2'd1;
        @(negedge clk) ext_trig = 1'b1; wait_idle(eb);
        check("R9 rising", logn - base, 1);
        @(negedge clk) ext_trig = 1'b0; tick(20);
        check("R9 fall ignored under rising", logn - base, 1);
        cfg_edge = 2'd2;
        @(negedge clk) ext_trig = 1'b1; tick(20);
        check("R9 rise ignored under falling", logn - base, 1);
        @(negedge clk) ext_trig = 1'b0; wait_idle(eb);
        check("R9 falling", logn - base, 2);
        cfg_edge = 2'd3;
        @(negedge clk) ext_trig = 1'b1; wait_idle(eb);
        @(negedge clk) ext_trig = 1'b0; wait_idle(eb);
        check("R9 both", logn - base, 4);
        cfg_edge = 2'd0;
        @(negedge clk) ext_trig = 1'b1; tick(20);
        @(negedge clk) ext_trig = 1'b0; tick(20);
        check("R9 none", logn - base, 4);
        pulse_sw(); wait_idle(eb);
        check("R9 sw with none", logn - base, 5);
        pulse_rd();

        // R12: triggers during a long conversion are ignored
        cfg_smp_code[15 +: 3] = 3'd7; cfg_edge = 2'd3;
        base = logn;
        pulse_sw(); tick(100);
        pulse_sw();
        @(negedge clk) ext_trig = 1'b1; tick(5);
        @(negedge clk) ext_trig = 1'b0;
        wait_idle(eb); tick(30);
        check("R12 one conversion", logn - base, 1);
        check("R12 idle", int'(busy), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1500000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule